// File: doc/BRIEF.md
# Low-Power Lane Turnaround Controller

This block hands transmit ownership of one bidirectional data lane from one end of a link to the other. It works only with low-power line states and covers both roles. As the current owner, it gives the lane up when asked. As the listener, it watches the far end's low-power states and takes the lane over when the far end hands it across. Every interval is a whole multiple of a programmable low-power period, here called the LPX length, and is counted in clock cycles.

The owner starts a handover with a single-cycle request. It then walks the lane through a stop, request and bridge pattern and holds the bridge state for four LPX before it stops driving. The listener sees the far end go to LP-10 and then LP-00. It waits a bounded settling window of one to two LPX and then drives the bridge state for five LPX. It finishes by driving LP-10 and then LP-11 to announce itself as the new owner. A cycle counter guards every wait for a far-end state. If the far end stalls, the block gives up and reports a timeout. A completed handover in either direction is reported with a one-cycle done pulse.

Top module: `lp_turnaround_ctrl`

## Requirements
- R1: After reset with the default RESET_OWNER=1, the block owns the lane: owner=1, drv_en=1, line_out=2'b11 (LP-11), and done=0, timeout=0. Line encoding: bit 1 is the positive wire and bit 0 the negative wire, so LP-11=2'b11, LP-10=2'b10 and LP-00=2'b00.
- R2: Let L be the effective LPX length. When req_release is sampled high in the owning idle state at edge k, line_out stays LP-11 until edge k+L. It is LP-10 from k+L and LP-00 from k+2L. At edge k+7L, drv_en and owner both drop to 0. While the block does not drive, line_out reads 2'b00.
- R3: After letting go, the block waits for the far end to show LP-10 and then LP-11. It pulses done high for exactly one cycle at the edge where LP-11 is sampled, and is then a listener.
- R4: While listening idle, the block arms when it samples LP-10 on line_in. If it then samples LP-00 at edge b, drv_en and owner rise together at edge b+S with line_out at LP-00, where S = L + min(sure_extra, L). They stay at LP-00 for 5L cycles.
- R5: After the 5L bridge, the block drives LP-10 for L cycles. It then drives LP-11 as the idle owner and pulses done for one cycle on that same edge.
- R6: L is lpx_cycles, or LPX_MIN (default 4) when lpx_cycles is smaller. L and sure_extra are captured when a turnaround leaves idle. Changes to either input during a turnaround have no effect on it.
- R7: In each wait for a far-end state, if the expected state has not been sampled by W cycles after entering the wait, timeout pulses for one cycle at that edge. W is wd_limit, and a limit of 0 acts as 1. The block then returns to listening idle with drv_en=0 and owner=0.
- R8: req_release is ignored when the block is not in the owning idle state, including during a turnaround in progress. line_in is ignored while the block owns the lane.
- R9: drv_en rises only while line_out is LP-00. It falls only right after a cycle of driving LP-00. owner changes on the same edges as drv_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lpx_cycles | input | LPX_W | Requested LPX length in clock cycles |
| sure_extra | input | LPX_W | Extra settling cycles beyond one LPX before the bridge drive (capped at one LPX) |
| wd_limit | input | WD_W | Cycle limit for each wait on the far end |
| req_release | input | 1 | Request to hand the lane to the far end |
| line_in | input | 2 | Sampled low-power line state from the far end |
| line_out | output | 2 | Low-power line state driven by this end |
| drv_en | output | 1 | Line driver enable |
| owner | output | 1 | This end currently owns the lane |
| done | output | 1 | One-cycle pulse when a handover completes |
| timeout | output | 1 | One-cycle pulse when a far-end wait expires |

## Verification
The hardest conditions to reach from the ports are the ones that need the far end to misbehave, or need a setting to change partway through a handover. These are a far end that stops after LP-10 and never reaches LP-00, a watchdog limit of zero, and a new LPX length or a second request arriving mid-release. The bench plays the far end on line_in. It runs full handovers in both directions, then stalls the far end on purpose, and rewrites lpx_cycles and pulses req_release a few cycles into a release. The scoreboard then demands the timings captured at the start. Every change on the outputs must match a queued expectation in both value and cycle, so a step that is early, late or spurious is caught.

// File: rtl/lp_ta_pkg.sv
// Package: shared state and line-code definitions for the turnaround controller.
// Assumes two-bit line codes with the positive wire in bit 1.
package lp_ta_pkg;

    typedef enum logic [3:0] {
        ST_OWN_IDLE,   // owner, idle, driving LP-11
        ST_REL_HI,     // release step: LP-11 for one LPX
        ST_REL_REQ,    // release step: LP-10 for one LPX
        ST_REL_BR,     // release step: LP-00 for one LPX
        ST_REL_GO,     // release bridge: LP-00 for four LPX
        ST_REL_W10,    // released, waiting for far-end LP-10
        ST_REL_W11,    // released, waiting for far-end LP-11
        ST_RX_IDLE,    // listener, idle
        ST_ACQ_W00,    // armed, waiting for far-end LP-00
        ST_ACQ_SURE,   // settling window before driving
        ST_ACQ_GET,    // acquire bridge: LP-00 for five LPX
        ST_ACQ_MARK    // acquire mark: LP-10 for one LPX
    } ta_state_e;

    localparam logic [1:0] LN_00 = 2'b00;
    localparam logic [1:0] LN_10 = 2'b10;
    localparam logic [1:0] LN_11 = 2'b11;

    // Purpose: tell whether a state waits on the far end (watchdog runs).
    function automatic logic is_far_wait(input ta_state_e st);
        return (st == ST_REL_W10) || (st == ST_REL_W11) || (st == ST_ACQ_W00);
    endfunction

    // Purpose: tell whether this end drives the lane in a state.
    function automatic logic is_driving(input ta_state_e st);
        return (st == ST_OWN_IDLE) || (st == ST_REL_HI) || (st == ST_REL_REQ) ||
               (st == ST_REL_BR) || (st == ST_REL_GO) ||
               (st == ST_ACQ_GET) || (st == ST_ACQ_MARK);
    endfunction

endpackage

// File: rtl/lp_ta_timing_cfg.sv
// Module: clamps the LPX length and the settling extra, captures them when a
// turnaround leaves idle, and derives every interval length from them.
// Assumes LPX_MIN >= 1 and LPX_MIN fits in LPX_W bits.
module lp_ta_timing_cfg #(
    parameter int LPX_W   = 8,
    parameter int LPX_MIN = 4,
    parameter int CW      = LPX_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [LPX_W-1:0] lpx_in,
    input  logic [LPX_W-1:0] extra_in,
    output logic [CW-1:0]    len_lpx,
    output logic [CW-1:0]    len_go,
    output logic [CW-1:0]    len_get,
    output logic [CW-1:0]    len_sure
);

    localparam logic [LPX_W-1:0] MIN_V = LPX_W'(LPX_MIN);

    logic [LPX_W-1:0] lpx_q, extra_q;
    logic [LPX_W-1:0] lpx_live, lpx_sel, extra_sel, extra_cap;

    // Purpose: clamp the live LPX length to its floor.
    always_comb lpx_live = (lpx_in < MIN_V) ? MIN_V : lpx_in;

    // Purpose: hold the values captured at the start of a turnaround.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lpx_q   <= MIN_V;
            extra_q <= '0;
        end else if (capture) begin
            lpx_q   <= lpx_live;
            extra_q <= extra_in;
        end
    end

    // Purpose: use live values in the capture cycle, held values afterwards.
    always_comb begin
        lpx_sel   = capture ? lpx_live : lpx_q;
        extra_sel = capture ? extra_in : extra_q;
        extra_cap = (extra_sel > lpx_sel) ? lpx_sel : extra_sel;
    end

    // Purpose: derive the interval lengths from the selected LPX.
    always_comb begin
        len_lpx  = CW'(lpx_sel);
        len_go   = CW'(lpx_sel) << 2;
        len_get  = (CW'(lpx_sel) << 2) + CW'(lpx_sel);
        len_sure = CW'(lpx_sel) + CW'(extra_cap);
    end

endmodule

// File: rtl/lp_ta_interval_timer.sv
// Module: down-counter for timed line states; expire is high in the last
// cycle of an interval. Assumes load carries (length - 1).
module lp_ta_interval_timer #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);

    logic [CW-1:0] cnt;

    // Purpose: load on state entry, else count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    // Purpose: flag the final cycle of the interval.
    always_comb expire = (cnt == '0);

    AST_TMR_REST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> cnt == '0); // R2

endmodule

// File: rtl/lp_ta_watchdog.sv
// Module: saturating cycle counter guarding each far-end wait; expired is
// high in the cycle whose closing edge is the W-th since the wait began.
// Assumes clr is asserted on every state change.
module lp_ta_watchdog #(
    parameter int WD_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    input  logic [WD_W-1:0] limit,
    output logic            expired
);

    localparam logic [WD_W-1:0] CNT_MAX = '1;

    logic [WD_W-1:0] cnt;
    logic [WD_W:0]   cnt_inc;

    // Purpose: count waiting cycles, clearing on state change, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (clr)                   cnt <= '0;
        else if (run && cnt != CNT_MAX) cnt <= cnt + WD_W'(1);
    end

    // Purpose: compare the elapsed count with the limit (zero acts as one).
    always_comb begin
        cnt_inc = {1'b0, cnt} + (WD_W+1)'(1);
        expired = run && (cnt_inc >= {1'b0, limit});
    end

    AST_WD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX); // R7

endmodule

// File: rtl/lp_ta_ctrl_fsm.sv
// Module: turnaround sequencer for both roles. Decodes line state, driver
// enable and ownership from its state register and issues done/timeout
// pulses. Assumes line_in is already synchronised to clk.
module lp_ta_ctrl_fsm
    import lp_ta_pkg::*;
#(
    parameter int CW          = 11,
    parameter bit RESET_OWNER = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_release,
    input  logic [1:0]    line_in,
    input  logic          tmr_expire,
    input  logic          wd_expired,
    input  logic [CW-1:0] len_lpx,
    input  logic [CW-1:0] len_go,
    input  logic [CW-1:0] len_get,
    input  logic [CW-1:0] len_sure,
    output logic          cfg_capture,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          wd_clr,
    output logic          wd_run,
    output logic [1:0]    line_out,
    output logic          drv_en,
    output logic          owner,
    output logic          done,
    output logic          timeout
);

    localparam ta_state_e RST_ST = RESET_OWNER ? ST_OWN_IDLE : ST_RX_IDLE;

    ta_state_e st_q, st_n;
    logic      done_n, tmo_n;

    // Purpose: choose the next state, timer load and pulse requests.
    always_comb begin
        st_n        = st_q;
        cfg_capture = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        done_n      = 1'b0;
        tmo_n       = 1'b0;
        unique case (st_q)
            ST_OWN_IDLE: if (req_release) begin
                st_n        = ST_REL_HI;
                cfg_capture = 1'b1;
                tmr_load    = 1'b1;
                tmr_val     = len_lpx - CW'(1);
            end
            ST_REL_HI: if (tmr_expire) begin
                st_n     = ST_REL_REQ;
                tmr_load = 1'b1;
                tmr_val  = len_lpx - CW'(1);
            end
            ST_REL_REQ: if (tmr_expire) begin
                st_n     = ST_REL_BR;
                tmr_load = 1'b1;
                tmr_val  = len_lpx - CW'(1);
            end
            ST_REL_BR: if (tmr_expire) begin
                st_n     = ST_REL_GO;
                tmr_load = 1'b1;
                tmr_val  = len_go - CW'(1);
            end
            ST_REL_GO: if (tmr_expire) st_n = ST_REL_W10;
            ST_REL_W10: begin
                if (line_in == LN_10) st_n = ST_REL_W11;
                else if (wd_expired) begin
                    st_n  = ST_RX_IDLE;
                    tmo_n = 1'b1;
                end
            end
            ST_REL_W11: begin
                if (line_in == LN_11) begin
                    st_n   = ST_RX_IDLE;
                    done_n = 1'b1;
                end else if (wd_expired) begin
                    st_n  = ST_RX_IDLE;
                    tmo_n = 1'b1;
                end
            end
            ST_RX_IDLE: if (line_in == LN_10) begin
                st_n        = ST_ACQ_W00;
                cfg_capture = 1'b1;
            end
            ST_ACQ_W00: begin
                if (line_in == LN_00) begin
                    st_n     = ST_ACQ_SURE;
                    tmr_load = 1'b1;
                    tmr_val  = len_sure - CW'(1);
                end else if (wd_expired) begin
                    st_n  = ST_RX_IDLE;
                    tmo_n = 1'b1;
                end
            end
            ST_ACQ_SURE: if (tmr_expire) begin
                st_n     = ST_ACQ_GET;
                tmr_load = 1'b1;
                tmr_val  = len_get - CW'(1);
            end
            ST_ACQ_GET: if (tmr_expire) begin
                st_n     = ST_ACQ_MARK;
                tmr_load = 1'b1;
                tmr_val  = len_lpx - CW'(1);
            end
            ST_ACQ_MARK: if (tmr_expire) begin
                st_n   = ST_OWN_IDLE;
                done_n = 1'b1;
            end
            default: st_n = RST_ST;
        endcase
    end

    // Purpose: register state and the completion/timeout pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RST_ST;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            st_q    <= st_n;
            done    <= done_n;
            timeout <= tmo_n;
        end
    end

    // Purpose: drive the watchdog controls from the current state.
    always_comb begin
        wd_clr = (st_n != st_q);
        wd_run = is_far_wait(st_q);
    end

    // Purpose: decode line state, driver enable and ownership from state.
    always_comb begin
        drv_en = is_driving(st_q);
        owner  = drv_en;
        unique case (st_q)
            ST_OWN_IDLE, ST_REL_HI: line_out = LN_11;
            ST_REL_REQ, ST_ACQ_MARK: line_out = LN_10;
            default:                 line_out = LN_00;
        endcase
    end

    AST_BRIDGE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> line_out == LN_00); // R9
    AST_BRIDGE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> $past(line_out) == LN_00); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_OWNER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && owner) |-> line_out == LN_11); // R5

endmodule

// File: rtl/lp_turnaround_ctrl.sv
// Module: top of the low-power lane turnaround controller. Connects the
// timing configuration, the interval timer, the far-end watchdog and the
// sequencer. Assumes all inputs are synchronous to clk.
module lp_turnaround_ctrl #(
    parameter int LPX_W       = 8,
    parameter int LPX_MIN     = 4,
    parameter int WD_W        = 12,
    parameter bit RESET_OWNER = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LPX_W-1:0] lpx_cycles,
    input  logic [LPX_W-1:0] sure_extra,
    input  logic [WD_W-1:0]  wd_limit,
    input  logic             req_release,
    input  logic [1:0]       line_in,
    output logic [1:0]       line_out,
    output logic             drv_en,
    output logic             owner,
    output logic             done,
    output logic             timeout
);

    localparam int CW = LPX_W + 3;

    logic          cfg_capture, tmr_load, tmr_expire, wd_clr, wd_run, wd_expired;
    logic [CW-1:0] tmr_val, len_lpx, len_go, len_get, len_sure;

    lp_ta_timing_cfg #(.LPX_W(LPX_W), .LPX_MIN(LPX_MIN), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .capture(cfg_capture),
        .lpx_in(lpx_cycles), .extra_in(sure_extra),
        .len_lpx(len_lpx), .len_go(len_go), .len_get(len_get), .len_sure(len_sure)
    );

    lp_ta_interval_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expire(tmr_expire)
    );

    lp_ta_watchdog #(.WD_W(WD_W)) u_wd (
        .clk(clk), .rst_n(rst_n), .clr(wd_clr), .run(wd_run),
        .limit(wd_limit), .expired(wd_expired)
    );

    lp_ta_ctrl_fsm #(.CW(CW), .RESET_OWNER(RESET_OWNER)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_release(req_release), .line_in(line_in),
        .tmr_expire(tmr_expire), .wd_expired(wd_expired),
        .len_lpx(len_lpx), .len_go(len_go), .len_get(len_get), .len_sure(len_sure),
        .cfg_capture(cfg_capture), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .wd_clr(wd_clr), .wd_run(wd_run),
        .line_out(line_out), .drv_en(drv_en), .owner(owner),
        .done(done), .timeout(timeout)
    );

    AST_TIMEOUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!drv_en && !owner)); // R7
    AST_OWNER_TRACKS_DRV: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(owner) |-> $changed(drv_en)); // R9

endmodule

// File: tb/lp_turnaround_ctrl_tb.sv
module lp_turnaround_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] lpx_cycles = 8'd4;
    logic [7:0] sure_extra = 8'd0;
    logic [11:0] wd_limit = 12'd40;
    logic       req_release = 1'b0;
    logic [1:0] line_in = 2'b11;
    logic [1:0] line_out;
    logic       drv_en, owner, done, timeout;

    always #2 clk = ~clk;

    lp_turnaround_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .lpx_cycles(lpx_cycles), .sure_extra(sure_extra),
        .wd_limit(wd_limit), .req_release(req_release), .line_in(line_in),
        .line_out(line_out), .drv_en(drv_en), .owner(owner),
        .done(done), .timeout(timeout)
    );

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int         q_cyc[$];
    logic [5:0] q_vec[$];
    string      q_tag[$];
    logic [5:0] last_vec;
    bit         mon_on = 0;

    function automatic logic [5:0] mk(input logic d, input logic t, input logic o,
                                      input logic e, input logic [1:0] ln);
        return {d, t, o, e, ln};
    endfunction

    task automatic push(input int c, input logic [5:0] v, input string tag);
        q_cyc.push_back(c);
        q_vec.push_back(v);
        q_tag.push_back(tag);
    endtask

    // Monitor: every change on the outputs must match the next expectation.
    always @(negedge clk) begin
        logic [5:0] now_v;
        now_v = {done, timeout, owner, drv_en, line_out};
        if (mon_on && now_v !== last_vec) begin
            total++;
            if (q_cyc.size() == 0) begin
                bad++;
                $display("FAIL unexpected change (R8) at cyc %0d: actual=%b expected=%b",
                         cyc, now_v, last_vec);
            end else begin
                int c; logic [5:0] v; string tg;
                c = q_cyc.pop_front(); v = q_vec.pop_front(); tg = q_tag.pop_front();
                if (v !== now_v || c != cyc) begin
                    bad++;
                    $display("FAIL %s: actual=%b@%0d expected=%b@%0d", tg, now_v, cyc, v, c);
                end
            end
        end
        last_vec = now_v;
    end

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    function automatic int eff_l(input int v);
        return (v < 4) ? 4 : v;
    endfunction

    // Release as owner; optionally disturb settings mid-way; far end replies or stalls.
    task automatic do_release(input bit reply, input bit disturb, input string tag);
        int L, k, m, w;
        L = eff_l(int'(lpx_cycles));
        w = (wd_limit == 0) ? 1 : int'(wd_limit);
        req_release = 1'b1;
        k = cyc + 1;
        push(k + L,     mk(0,0,1,1,2'b10), tag);
        push(k + 2*L,   mk(0,0,1,1,2'b00), tag);
        push(k + 7*L,   mk(0,0,0,0,2'b00), tag);
        @(negedge clk);
        req_release = 1'b0;
        if (disturb) begin
            repeat (3) @(negedge clk);
            lpx_cycles = 8'd9;                 // R6: ignored mid-sequence
            req_release = 1'b1;                // R8: ignored mid-sequence
            @(negedge clk);
            req_release = 1'b0;
        end
        if (reply) begin
            wait_until(k + 7*L + 1);
            line_in = 2'b10;
            repeat (2) @(negedge clk);
            line_in = 2'b11;
            m = cyc + 1;
            push(m,     mk(1,0,0,0,2'b00), "R3");
            push(m + 1, mk(0,0,0,0,2'b00), "R3");
            wait_until(m + 3);
        end else begin
            push(k + 7*L + w,     mk(0,1,0,0,2'b00), "R7");
            push(k + 7*L + w + 1, mk(0,0,0,0,2'b00), "R7");
            wait_until(k + 7*L + w + 3);
        end
    endtask

    // Acquire as listener: far end shows LP-10 then LP-00.
    task automatic do_acquire(input string tag);
        int L, x, S, b;
        L = eff_l(int'(lpx_cycles));
        x = int'(sure_extra);
        S = L + ((x > L) ? L : x);
        line_in = 2'b10;
        repeat (2) @(negedge clk);
        line_in = 2'b00;
        b = cyc + 1;
        push(b + S,           mk(0,0,1,1,2'b00), tag);
        push(b + S + 5*L,     mk(0,0,1,1,2'b10), "R5");
        push(b + S + 6*L,     mk(1,0,1,1,2'b11), "R5");
        push(b + S + 6*L + 1, mk(0,0,1,1,2'b11), "R5");
        wait_until(b + S + 6*L + 3);
        line_in = 2'b11;
    endtask

    // Listener sees LP-10 but LP-00 never follows.
    task automatic acquire_stall();
        int a, w;
        w = (wd_limit == 0) ? 1 : int'(wd_limit);
        line_in = 2'b10;
        a = cyc + 1;
        @(negedge clk);
        line_in = 2'b11;
        push(a + w,     mk(0,1,0,0,2'b00), "R7");
        push(a + w + 1, mk(0,0,0,0,2'b00), "R7");
        wait_until(a + w + 3);
    endtask

    task automatic check_idle(input logic [5:0] exp_v, input string tag);
        logic [5:0] v;
        v = {done, timeout, owner, drv_en, line_out};
        total++;
        if (v !== exp_v) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, v, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle(mk(0,0,1,1,2'b11), "R1");
        mon_on = 1;

        // R8: far-end states while owning have no effect
        line_in = 2'b10; repeat (5) @(negedge clk);
        line_in = 2'b00; repeat (5) @(negedge clk);
        line_in = 2'b11; repeat (2) @(negedge clk);
        check_idle(mk(0,0,1,1,2'b11), "R8");

        do_release(1, 0, "R2");

        // R8: request while listening is ignored
        req_release = 1'b1; @(negedge clk); req_release = 1'b0;
        repeat (6) @(negedge clk);
        check_idle(mk(0,0,0,0,2'b00), "R8");

        do_acquire("R4");

        lpx_cycles = 8'd1;                     // R6: clamped to 4
        do_release(1, 0, "R6");
        sure_extra = 8'd100;                   // R4: extra capped at L
        do_acquire("R4");

        lpx_cycles = 8'd5; sure_extra = 8'd0;
        do_release(1, 1, "R6");
        lpx_cycles = 8'd6; sure_extra = 8'd2;
        do_acquire("R4");

        wd_limit = 12'd40;
        do_release(0, 0, "R2");                // far end silent -> timeout
        acquire_stall();
        wd_limit = 12'd0;                      // R7: zero acts as one
        acquire_stall();
        wd_limit = 12'd40;
        lpx_cycles = 8'd4; sure_extra = 8'd1;
        do_acquire("R4");

        repeat (10) @(negedge clk);
        total++;
        if (q_cyc.size() != 0) begin
            bad++;
            $display("FAIL R2: actual=%0d pending expected=0", q_cyc.size());
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1: actual=hung expected=finished");
        finish_run();
    end

endmodule